// File: doc/BRIEF.md
# Audio Sample Word Unpacker

This block sits between a transmit sample queue and a serial audio line encoder. It takes one 32-bit word at a time and turns it into one or two subframe descriptors. Each descriptor holds a 24-bit payload, the four per-subframe flag bits (parity, channel status, user, validity), a 4-bit preamble code and a channel tag.

A 2-bit format input chooses how the word is read. Three formats carry a right-aligned sample of 16, 20 or 24 bits. A raw format carries every subframe field explicitly. A packing input splits a 16-bit word into a left and a right sample, which leave the block in that order.

Both sides use a valid/ready handshake. The format and packing inputs are captured together with the word, so software can retune them between words without disturbing a word that is already inside the block. Biphase-mark coding, preamble waveforms and parity computation for the non-raw formats belong to the stage that follows.

Top module: `smp_unpack`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `in_ready` is 1.
- R2: Format 00 with packing off gives a payload of word bits 15..0 placed in payload bits 23..8, with bits 7..0 zero. The flags, the preamble and the channel tag are 0, and word bits 31..16 have no effect.
- R3: Format 01 gives a payload of word bits 19..0 placed in payload bits 23..4, with bits 3..0 zero. The flags, the preamble and the tag are 0, and word bits 31..20 are ignored.
- R4: Format 10 gives a payload equal to word bits 23..0. The flags, the preamble and the tag are 0, and word bits 31..24 are ignored.
- R5: Format 11 (raw) gives parity = bit 31, channel status = bit 30, user = bit 29 and validity = bit 28. The payload is word bits 27..4, which puts the 20 audio bits in payload 23..4 and the aux nibble in payload 3..0. The preamble code is bits 3..0.
- R6: Format 00 with packing on gives two subframes. The first has tag 0 and carries bits 15..0. The second has tag 1 and carries bits 31..16. Both are placed as in R2.
- R7: The packing input has no effect under formats 01, 10 and 11. Each such word gives exactly one subframe, with tag 0.
- R8: While the first subframe of a packed word is pending, `in_ready` is 0, even when `out_ready` is 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, every output field stays unchanged on the next cycle, and `in_ready` is 0.
- R10: The format and packing inputs are sampled when a word is accepted. Changing them afterwards does not alter that word's subframes.
- R11: `in_ready` is 1 when the block holds nothing, or when the last subframe of the current word is being taken. This allows one word per cycle back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Word format: 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| pack_en | input | 1 | Two 16-bit samples per word (format 00 only) |
| in_valid | input | 1 | Input word offered |
| in_word | input | 32 | Input word |
| in_ready | output | 1 | Block accepts the offered word |
| out_valid | output | 1 | Subframe descriptor valid |
| out_ready | input | 1 | Downstream takes the descriptor |
| out_payload | output | 24 | MSB-aligned audio payload |
| out_pflag | output | 1 | Parity bit (raw only) |
| out_cflag | output | 1 | Channel-status bit (raw only) |
| out_uflag | output | 1 | User bit (raw only) |
| out_vflag | output | 1 | Validity bit (raw only) |
| out_pre | output | 4 | Preamble code (raw only) |
| out_chan | output | 1 | 0 for left or single, 1 for the right sample of a packed word |

## Verification
Assertions check the following on every cycle:
- output stability under backpressure;
- the blocking of input while a packed word still owes its right half;
- the left-to-right step of a packed pair;
- that `in_ready` never rises without room.

Only the bench's scenarios can show the bit placement of each format, the zero padding, the ignored upper bits and the independence from format changes made after acceptance. It sweeps every format, with packing on and off, over walking-one and fixed patterns and compares against an arithmetic model. It also runs directed back-to-back transfers that show the one-word-per-cycle throughput.

// File: rtl/smp_unpack_pkg.sv
package smp_unpack_pkg;

    localparam int WORD_W  = 32;
    localparam int PAY_W   = 24;
    localparam int PRE_W   = 4;
    localparam int FLAG_W  = 4;
    localparam int S16_W   = 16;
    localparam int S20_W   = 20;
    localparam int S24_W   = 24;
    localparam int RAW_LSB = PRE_W;
    localparam int RAW_MSB = WORD_W - FLAG_W - 1;

    typedef enum logic [1:0] {
        FMT_16  = 2'b00,
        FMT_20  = 2'b01,
        FMT_24  = 2'b10,
        FMT_RAW = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        fmt_e              fmt;
        logic              paired;
    } held_t;

    typedef struct packed {
        logic [PAY_W-1:0] payload;
        logic             pflag;
        logic             cflag;
        logic             uflag;
        logic             vflag;
        logic [PRE_W-1:0] pre;
        logic             chan;
    } subframe_t;

    function automatic logic pair_mode(fmt_e f, logic pack);
        return pack && (f == FMT_16);
    endfunction

endpackage

// File: rtl/smp_unpack_ctrl.sv
module smp_unpack_ctrl
    import smp_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        fmt_sel,
    input  logic              pack_en,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output held_t             held,
    output logic              phase
);

    logic pair_open;
    logic accept;
    logic take;

    assign pair_open = out_valid && held.paired && !phase;
    assign in_ready  = !out_valid || (out_ready && !pair_open);
    assign accept    = in_valid && in_ready;
    assign take      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            phase     <= 1'b0;
            held      <= '0;
        end else if (accept) begin
            held.word   <= in_word;
            held.fmt    <= fmt_e'(fmt_sel);
            held.paired <= pair_mode(fmt_e'(fmt_sel), pack_en);
            out_valid   <= 1'b1;
            phase       <= 1'b0;
        end else if (take) begin
            if (pair_open) begin
                phase <= 1'b1;
            end else begin
                out_valid <= 1'b0;
                phase     <= 1'b0;
            end
        end
    end

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(held) && $stable(phase))); // R9

    AST_RIGHT_AFTER_LEFT: assert property (@(posedge clk) disable iff (rst)
        (take && held.paired && !phase) |=> (out_valid && phase && $stable(held))); // R6

    AST_LEFT_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && out_valid && held.paired && !phase) |=> (out_valid && $stable(held))); // R8

    AST_CAPTURE_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid && !phase && held.word == $past(in_word))); // R10

endmodule

// File: rtl/smp_unpack_fmt.sv
module smp_unpack_fmt
    import smp_unpack_pkg::*;
(
    input  held_t     held,
    input  logic      phase,
    output subframe_t sf
);

    logic [S16_W-1:0] lane16;

    assign lane16 = (held.paired && phase) ? held.word[2*S16_W-1:S16_W]
                                           : held.word[S16_W-1:0];

    always_comb begin
        sf      = '0;
        sf.chan = held.paired && phase;
        unique case (held.fmt)
            FMT_16:  sf.payload = {lane16, {(PAY_W-S16_W){1'b0}}};
            FMT_20:  sf.payload = {held.word[S20_W-1:0], {(PAY_W-S20_W){1'b0}}};
            FMT_24:  sf.payload = held.word[S24_W-1:0];
            FMT_RAW: begin
                sf.payload = held.word[RAW_MSB:RAW_LSB];
                sf.pflag   = held.word[WORD_W-1];
                sf.cflag   = held.word[WORD_W-2];
                sf.uflag   = held.word[WORD_W-3];
                sf.vflag   = held.word[WORD_W-4];
                sf.pre     = held.word[PRE_W-1:0];
            end
            default: sf = '0;
        endcase
    end

endmodule

// File: rtl/smp_unpack.sv
module smp_unpack
    import smp_unpack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fmt_sel,
    input  logic              pack_en,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAY_W-1:0]  out_payload,
    output logic              out_pflag,
    output logic              out_cflag,
    output logic              out_uflag,
    output logic              out_vflag,
    output logic [PRE_W-1:0]  out_pre,
    output logic              out_chan
);

    held_t     held;
    logic      phase;
    subframe_t sf;

    smp_unpack_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .fmt_sel   (fmt_sel),
        .pack_en   (pack_en),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .held      (held),
        .phase     (phase)
    );

    smp_unpack_fmt u_fmt (
        .held  (held),
        .phase (phase),
        .sf    (sf)
    );

    assign out_payload = sf.payload;
    assign out_pflag   = sf.pflag;
    assign out_cflag   = sf.cflag;
    assign out_uflag   = sf.uflag;
    assign out_vflag   = sf.vflag;
    assign out_pre     = sf.pre;
    assign out_chan    = sf.chan;

    AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!out_valid || out_ready)); // R11

    AST_STALL_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> ($stable(out_payload) && $stable(out_pre) && $stable(out_chan))); // R9

endmodule

// File: tb/smp_unpack_bench.sv
module smp_unpack_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  fmt_sel = 2'b00;
    logic        pack_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_payload;
    logic        out_pflag, out_cflag, out_uflag, out_vflag;
    logic [3:0]  out_pre;
    logic        out_chan;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    smp_unpack u_smp_unpack (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .pack_en(pack_en),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_payload(out_payload),
        .out_pflag(out_pflag), .out_cflag(out_cflag), .out_uflag(out_uflag),
        .out_vflag(out_vflag), .out_pre(out_pre), .out_chan(out_chan)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [32:0] model(input int mode, input bit pack, input logic [31:0] w, input bit right);
        logic [31:0] pay;
        logic [3:0]  fl;
        logic [3:0]  pre;
        bit          paired;
        paired = pack && mode == 0;
        fl = 4'h0;
        pre = 4'h0;
        case (mode)
            0: pay = ((paired && right) ? (w >> 16) : (w % 32'h10000)) * 256;
            1: pay = (w % 32'h100000) * 16;
            2: pay = w % 32'h1000000;
            default: begin
                pay = (w >> 4) % 32'h1000000;
                fl  = w[31:28];
                pre = w % 16;
            end
        endcase
        return {pay[23:0], fl, pre, paired && right};
    endfunction

    function automatic logic [32:0] seen();
        return {out_payload, out_pflag, out_cflag, out_uflag, out_vflag, out_pre, out_chan};
    endfunction

    function automatic string tag(input int mode, input bit pack);
        if (pack && mode != 0) return "R7/R10";
        case (mode)
            0: return pack ? "R6/R10" : "R2/R10";
            1: return "R3/R10";
            2: return "R4/R10";
            default: return "R5/R10";
        endcase
    endfunction

    task automatic txn(input int mode, input bit pack, input logic [31:0] w);
        logic [32:0] first;
        bit paired;
        paired = pack && mode == 0;
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk("R11 idle ready", in_ready, 1);
        fmt_sel = mode[1:0];
        pack_en = pack;
        in_valid = 1'b1;
        in_word = w;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_word = ~w;
        fmt_sel = ~mode[1:0];
        pack_en = ~pack;
        #1;
        chk("R10 valid after accept", out_valid, 1);
        first = seen();
        chk(tag(mode, pack), first, model(mode, pack, w, 0));
        @(negedge clk);
        #1;
        chk("R9 stall hold", {out_valid, seen()}, {1'b1, first});
        chk("R9 stall no ready", in_ready, 0);
        out_ready = 1'b1;
        #1;
        if (paired) chk("R8 left pending", in_ready, 0);
        else        chk("R11 last taken", in_ready, 1);
        @(posedge clk);
        if (paired) begin
            @(negedge clk);
            #1;
            chk("R6 right valid", out_valid, 1);
            chk(tag(mode, pack), seen(), model(mode, pack, w, 1));
            @(posedge clk);
        end
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk("R7/R11 drained", out_valid, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5C3_5A3C;
        pats[3] = 32'h1234_5678;

        repeat (2) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        #1;
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset ready", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        #1;
        chk("R1 after reset valid", out_valid, 0);
        chk("R1 after reset ready", in_ready, 1);

        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int b = 0; b < 32; b++) txn(m, p[0], 32'h1 << b);
                for (int k = 0; k < 4; k++) txn(m, p[0], pats[k]);
            end
        end

        // R11: back-to-back words, format 10
        @(negedge clk);
        fmt_sel = 2'b10; pack_en = 1'b0; in_valid = 1'b1; in_word = 32'h00AB_CDEF;
        @(posedge clk);
        @(negedge clk);
        in_word = 32'h0012_3456; out_ready = 1'b1;
        #1;
        chk("R11 concurrent ready", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R11 next word", {out_valid, out_payload}, {1'b1, 24'h12_3456});
        @(posedge clk);

        // R8: packed word followed at once by another
        @(negedge clk);
        fmt_sel = 2'b00; pack_en = 1'b1; in_valid = 1'b1; in_word = 32'hBEEF_CAFE;
        @(posedge clk);
        @(negedge clk);
        in_word = 32'h1111_2222;
        #1;
        chk("R8 blocked on left", in_ready, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 right shown", {out_chan, out_payload}, {1'b1, 24'hBEEF00});
        chk("R8 ready on right", in_ready, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R8 next left", {out_chan, out_payload}, {1'b0, 24'h222200});
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk("R8 drained", out_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule